// File: doc/BRIEF.md
# Command-Driven SPI NOR Flash Controller

This block lets software run one SPI NOR flash operation at a time through a small bank of 32-bit control registers. Software first sets the flash address, a byte count and a bus mode. For an operation that sends data, it also fills a page-sized data window with 32-bit words. It then writes the command register with an 8-bit opcode, a 4-bit transaction kind and the launch bit. The block lowers chip select and shifts out the opcode, then a 24-bit address if the kind needs one, then the data bytes, all on one data lane in SPI mode 0. After the frame it raises chip select and clears the launch bit, which software polls.

For read kinds, each byte that arrives from the flash is stored in the data window. The first byte of a transfer goes to the lowest byte lane of word 0. Only one page is moved per command. A byte count of zero gives an opcode-only or opcode-plus-address frame, as used by erase.

Top module: `nor_cmd_ctrl`

## Requirements
- R1: After reset the command register reads 0xFFFFC000, the count, address, bus-mode and fast-read registers read 0, chip select is high and SCLK is low.
- R2: In the command register at offset 0x18, bit 0 is the launch/busy flag, bits 4:1 are the kind, bit 5 is the move flag and bits 13:6 are the opcode. The first byte sent is the opcode. Writing a 1 to bit 0 starts a frame. Bit 0 reads 1 until the frame ends and 0 afterwards.
- R3: A write to the command register while bit 0 is 1 changes neither the register nor the frame in progress.
- R4: SCLK is the system clock divided by 2 and idles low. Data goes out MSB first. MOSI changes only while SCLK is low. MISO is sampled on the SCLK rising edge.
- R5: Kinds 0, 3, 4, 5, 10, 11, 12 and 13 send the opcode, then address bits 23:0 MSB first, then the data phase. Kinds 7 and 8 send only the opcode. Every other kind sends the opcode and then the data phase.
- R6: For the sending kinds (all except 2, 10, 13, 14 and 15), data byte i is taken from byte lane i mod 4 (bits 8*(i mod 4)+7 : 8*(i mod 4)) of window word i div 4. The window starts at offset 0x100.
- R7: For the read kinds 2, 10, 13, 14 and 15, received data byte i is written into the same window position. Window bytes at or beyond the transferred count keep their previous value.
- R8: The data phase moves min(count, PAGE_BYTES) bytes. The count register is at offset 0x14. A count of 0 gives no data phase.
- R9: The count and address registers are captured at launch. Writing them during a frame does not change that frame.
- R10: Chip select stays low from the first opcode bit to the last data bit, with exactly one rising edge per frame. After it rises it stays high for at least two system clocks.
- R11: The bus-mode register (0x04, 2 bits), the fast-read register (0x10, 2 bits), the count register (0x14, 16 bits) and the address register (0x24, 32 bits) read back the values written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 9 | Byte address. Bit 8 set selects the data window |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sclk | output | 1 | SPI clock, mode 0 |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The bench builds the block with PAGE_BYTES set to 16. A page then holds only four window words, so every byte count from zero through two past the page size can be swept for one sending kind and one reading kind. That sweep covers the clamp and the partial last word, as well as the bytes left untouched after a short read. All sixteen kinds are also run with a fixed count to check each frame shape. A bench flash model records MOSI and replies on MISO with a byte computed from its position in the frame. One further frame is disturbed in mid-flight by a second command write and by new count and address values.

// File: rtl/nor_cmd_pkg.sv
// Package: shared register offsets, command-kind coding and frame-shape
// decode for the SPI NOR command controller.
// Assumes: register offsets are byte addresses within the register space.
package nor_cmd_pkg;

    localparam logic [7:0] OFS_MODE  = 8'h04;
    localparam logic [7:0] OFS_FAST  = 8'h10;
    localparam logic [7:0] OFS_COUNT = 8'h14;
    localparam logic [7:0] OFS_CMD   = 8'h18;
    localparam logic [7:0] OFS_ADDR  = 8'h24;

    localparam int COUNT_REG_W = 16;

    // Shape of a frame, decoded from the 4-bit command kind.
    typedef struct packed {
        logic with_addr;   // 24-bit address follows the opcode
        logic with_data;   // a data phase follows
        logic data_in;     // data phase receives into the window
    } frame_shape_t;

    // Map a command kind to the frame it produces.
    function automatic frame_shape_t shape_of(input logic [3:0] kind);
        frame_shape_t s;
        s.with_addr = 1'b0;
        s.with_data = 1'b1;
        s.data_in   = 1'b0;
        case (kind)
            4'd0, 4'd3, 4'd4, 4'd5, 4'd11, 4'd12: s.with_addr = 1'b1;
            4'd10, 4'd13: begin
                s.with_addr = 1'b1;
                s.data_in   = 1'b1;
            end
            4'd2, 4'd14, 4'd15: s.data_in = 1'b1;
            4'd7, 4'd8: s.with_data = 1'b0;
            default: ;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/nor_cmd_buf.sv
// Module: page-sized byte store, shared by the bus (32-bit word port) and
// the sequencer (byte port).
// Assumes: PAGE_BYTES is a power of two and a multiple of 4. When both
// ports write the same byte in one cycle, the bus write wins.
module nor_cmd_buf #(
    parameter int PAGE_BYTES = 256,
    localparam int PAGE_WORDS = PAGE_BYTES / 4,
    localparam int WIDX_W = $clog2(PAGE_WORDS),
    localparam int BIDX_W = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              sw_we,
    input  logic [WIDX_W-1:0] sw_widx,
    input  logic [31:0]       sw_wdata,
    output logic [31:0]       sw_rdata,
    input  logic              hw_we,
    input  logic [BIDX_W-1:0] hw_bidx,
    input  logic [7:0]        hw_wdata,
    output logic [7:0]        hw_rdata
);

    logic [7:0] mem [PAGE_BYTES];

    for (genvar b = 0; b < PAGE_BYTES; b++) begin : g_byte
        // One byte cell: the bus word write has priority over the sequencer.
        always_ff @(posedge clk) begin
            if (sw_we && sw_widx == WIDX_W'(b / 4))
                mem[b] <= sw_wdata[8*(b%4) +: 8];
            else if (hw_we && hw_bidx == BIDX_W'(b))
                mem[b] <= hw_wdata;
        end
    end

    for (genvar j = 0; j < 4; j++) begin : g_lane
        // Assemble the read word in little-endian byte order.
        assign sw_rdata[8*j +: 8] = mem[{sw_widx, 2'(j)}];
    end

    assign hw_rdata = mem[hw_bidx];

endmodule

// File: rtl/nor_cmd_shift.sv
// Module: one-byte SPI mode-0 shifter. SCLK runs at half the system clock.
// MOSI is updated on the falling half and MISO is sampled on the rising half.
// Assumes: start is only given while busy is low. done pulses for one cycle
// after the eighth falling edge, and rx_byte holds its value until the next start.
module nor_cmd_shift (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    output logic       busy,
    output logic       done,
    output logic [7:0] rx_byte,
    output logic       sclk,
    output logic       mosi,
    input  logic       miso
);

    logic [7:0] tx_q;
    logic [2:0] bit_q;

    // Bit engine: load, rise (sample), fall (shift), finish after 8 bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q    <= '0;
            rx_byte <= '0;
            bit_q   <= '0;
            busy    <= 1'b0;
            done    <= 1'b0;
            sclk    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    tx_q  <= tx_byte;
                    bit_q <= '0;
                    busy  <= 1'b1;
                end
            end else if (!sclk) begin
                sclk    <= 1'b1;
                rx_byte <= {rx_byte[6:0], miso};
            end else begin
                sclk  <= 1'b0;
                tx_q  <= {tx_q[6:0], 1'b0};
                bit_q <= bit_q + 3'd1;
                if (bit_q == 3'd7) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign mosi = tx_q[7];

    AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> $stable(mosi)); // R4
    AST_SCLK_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |=> !sclk); // R4

endmodule

// File: rtl/nor_cmd_seq.sv
// Module: frame sequencer. At launch it captures opcode, kind, count and
// address. It then feeds the shifter byte by byte (opcode, address, data),
// stores received data bytes, and holds chip select high for a gap before
// it reports done.
// Assumes: start only arrives while idle. The count is clamped to one page.
module nor_cmd_seq
    import nor_cmd_pkg::*;
#(
    parameter int PAGE_BYTES = 256,
    parameter int GAP_CYCLES = 2,
    localparam int BIDX_W = $clog2(PAGE_BYTES),
    localparam int CNT_W = $clog2(PAGE_BYTES + 1),
    localparam int POS_W = $clog2(PAGE_BYTES + 5),
    localparam int GAP_W = $clog2(GAP_CYCLES + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [3:0]             kind,
    input  logic [7:0]             opcode,
    input  logic [COUNT_REG_W-1:0] count,
    input  logic [23:0]            faddr,
    output logic                   sh_start,
    output logic [7:0]             sh_tx,
    input  logic                   sh_done,
    input  logic [7:0]             sh_rx,
    output logic [BIDX_W-1:0]      buf_idx,
    input  logic [7:0]             buf_rdata,
    output logic                   buf_we,
    output logic                   cs_n,
    output logic                   done
);

    typedef enum logic [1:0] {S_IDLE, S_LOAD, S_WAIT, S_GAP} seq_state_e;

    seq_state_e   state_q;
    logic [7:0]   op_q;
    logic [23:0]  addr_q;
    logic [2:0]   hdr_q;
    logic [CNT_W-1:0] ndata_q;
    logic         rd_q;
    logic [POS_W-1:0] pos_q;
    logic [GAP_W-1:0] gap_q;
    frame_shape_t shp;
    logic [POS_W-1:0] dpos;
    logic         in_data;
    logic         last_byte;

    assign shp       = shape_of(kind);
    assign dpos      = pos_q - POS_W'(hdr_q);
    assign in_data   = pos_q >= POS_W'(hdr_q);
    assign last_byte = pos_q == POS_W'(hdr_q) + POS_W'(ndata_q) - POS_W'(1);
    assign buf_idx   = dpos[BIDX_W-1:0];

    // Pick the byte for the current frame position.
    always_comb begin
        if (pos_q == '0)
            sh_tx = op_q;
        else if (!in_data)
            sh_tx = addr_q[8*(3 - int'(pos_q)) +: 8];
        else if (rd_q)
            sh_tx = 8'h00;
        else
            sh_tx = buf_rdata;
    end

    assign sh_start = state_q == S_LOAD;
    assign buf_we   = state_q == S_WAIT && sh_done && in_data && rd_q;

    // Frame control: capture at launch, step per byte, then the CS gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            op_q    <= '0;
            addr_q  <= '0;
            hdr_q   <= 3'd1;
            ndata_q <= '0;
            rd_q    <= 1'b0;
            pos_q   <= '0;
            gap_q   <= '0;
            cs_n    <= 1'b1;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state_q)
                S_IDLE: if (start) begin
                    op_q    <= opcode;
                    addr_q  <= faddr;
                    hdr_q   <= shp.with_addr ? 3'd4 : 3'd1;
                    rd_q    <= shp.data_in;
                    if (!shp.with_data)
                        ndata_q <= '0;
                    else if (count > COUNT_REG_W'(PAGE_BYTES))
                        ndata_q <= CNT_W'(PAGE_BYTES);
                    else
                        ndata_q <= count[CNT_W-1:0];
                    pos_q   <= '0;
                    cs_n    <= 1'b0;
                    state_q <= S_LOAD;
                end
                S_LOAD: state_q <= S_WAIT;
                S_WAIT: if (sh_done) begin
                    if (last_byte) begin
                        cs_n    <= 1'b1;
                        gap_q   <= '0;
                        state_q <= S_GAP;
                    end else begin
                        pos_q   <= pos_q + POS_W'(1);
                        state_q <= S_LOAD;
                    end
                end
                S_GAP: begin
                    gap_q <= gap_q + GAP_W'(1);
                    if (gap_q == GAP_W'(GAP_CYCLES - 1)) begin
                        done    <= 1'b1;
                        state_q <= S_IDLE;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |=> cs_n); // R10
    AST_CS_DURING_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_LOAD || state_q == S_WAIT) |-> !cs_n); // R10

endmodule

// File: rtl/nor_cmd_ctrl.sv
// Module: top of the SPI NOR command controller. It holds the register file,
// decodes the bus into the register space (bus_addr[8]=0) and the data
// window (bus_addr[8]=1), and launches the sequencer from the command register.
// Assumes: single-cycle bus writes and combinational reads. Only the
// single-lane bus is driven; the mode and fast-read values are stored only.
module nor_cmd_ctrl
    import nor_cmd_pkg::*;
#(
    parameter int PAGE_BYTES = 256,
    localparam int PAGE_WORDS = PAGE_BYTES / 4,
    localparam int WIDX_W = $clog2(PAGE_WORDS),
    localparam int BIDX_W = $clog2(PAGE_BYTES)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [8:0]  bus_addr,
    input  logic        bus_wr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        spi_cs_n,
    output logic        spi_sclk,
    output logic        spi_mosi,
    input  logic        spi_miso
);

    logic [1:0]             mode_q;
    logic [1:0]             fast_q;
    logic [COUNT_REG_W-1:0] count_q;
    logic [31:0]            addr_q;
    logic                   cmd_valid_q;
    logic [3:0]             cmd_kind_q;
    logic                   cmd_move_q;
    logic [7:0]             cmd_op_q;

    logic                   csr_wr;
    logic                   win_wr;
    logic                   cmd_wr;
    logic                   launch;
    logic [31:0]            win_rdata;
    logic                   sh_start;
    logic [7:0]             sh_tx;
    logic                   sh_busy;
    logic                   sh_done;
    logic [7:0]             sh_rx;
    logic [BIDX_W-1:0]      buf_idx;
    logic [7:0]             buf_rdata;
    logic                   buf_we;
    logic                   seq_done;

    assign csr_wr = bus_wr && !bus_addr[8];
    assign win_wr = bus_wr && bus_addr[8];
    assign cmd_wr = csr_wr && bus_addr[7:0] == OFS_CMD;
    assign launch = cmd_wr && !cmd_valid_q && bus_wdata[0];

    // Register file: plain registers plus the interlocked command register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q      <= '0;
            fast_q      <= '0;
            count_q     <= '0;
            addr_q      <= '0;
            cmd_valid_q <= 1'b0;
            cmd_kind_q  <= '0;
            cmd_move_q  <= 1'b0;
            cmd_op_q    <= '0;
        end else begin
            if (csr_wr) begin
                case (bus_addr[7:0])
                    OFS_MODE:  mode_q  <= bus_wdata[1:0];
                    OFS_FAST:  fast_q  <= bus_wdata[1:0];
                    OFS_COUNT: count_q <= bus_wdata[COUNT_REG_W-1:0];
                    OFS_ADDR:  addr_q  <= bus_wdata;
                    default: ;
                endcase
            end
            if (cmd_wr && !cmd_valid_q) begin
                cmd_valid_q <= bus_wdata[0];
                cmd_kind_q  <= bus_wdata[4:1];
                cmd_move_q  <= bus_wdata[5];
                cmd_op_q    <= bus_wdata[13:6];
            end else if (seq_done) begin
                cmd_valid_q <= 1'b0;
            end
        end
    end

    // Read mux over registers and the data window.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr[8]) begin
            bus_rdata = win_rdata;
        end else begin
            case (bus_addr[7:0])
                OFS_MODE:  bus_rdata = {30'b0, mode_q};
                OFS_FAST:  bus_rdata = {30'b0, fast_q};
                OFS_COUNT: bus_rdata = {{(32-COUNT_REG_W){1'b0}}, count_q};
                OFS_CMD:   bus_rdata = {18'h3FFFF, cmd_op_q, cmd_move_q,
                                        cmd_kind_q, cmd_valid_q};
                OFS_ADDR:  bus_rdata = addr_q;
                default:   bus_rdata = '0;
            endcase
        end
    end

    nor_cmd_buf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
        .clk      (clk),
        .sw_we    (win_wr),
        .sw_widx  (bus_addr[WIDX_W+1:2]),
        .sw_wdata (bus_wdata),
        .sw_rdata (win_rdata),
        .hw_we    (buf_we),
        .hw_bidx  (buf_idx),
        .hw_wdata (sh_rx),
        .hw_rdata (buf_rdata)
    );

    nor_cmd_seq #(.PAGE_BYTES(PAGE_BYTES)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (launch),
        .kind      (bus_wdata[4:1]),
        .opcode    (bus_wdata[13:6]),
        .count     (count_q),
        .faddr     (addr_q[23:0]),
        .sh_start  (sh_start),
        .sh_tx     (sh_tx),
        .sh_done   (sh_done),
        .sh_rx     (sh_rx),
        .buf_idx   (buf_idx),
        .buf_rdata (buf_rdata),
        .buf_we    (buf_we),
        .cs_n      (spi_cs_n),
        .done      (seq_done)
    );

    nor_cmd_shift u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (sh_start),
        .tx_byte (sh_tx),
        .busy    (sh_busy),
        .done    (sh_done),
        .rx_byte (sh_rx),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi),
        .miso    (spi_miso)
    );

    AST_IDLE_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk); // R4
    AST_BUSY_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_valid_q) |=> $stable(cmd_op_q) && $stable(cmd_kind_q)); // R3
    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> !cmd_valid_q); // R2
    AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        sh_start |-> !sh_busy); // R4

endmodule

// File: tb/tb_nor_cmd_ctrl.sv
// Bench: small-page build (16 bytes). A flash model records MOSI and
// answers on MISO with a byte computed from its position in the frame.
module tb_nor_cmd_ctrl;

    localparam int PG = 16;
    localparam int NW = PG / 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        spi_cs_n, spi_sclk, spi_mosi, spi_miso;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    nor_cmd_ctrl #(.PAGE_BYTES(PG)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_cs_n(spi_cs_n),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    // ---------------- flash model ----------------
    logic [7:0] cap [64];
    int capn = 0;
    int bitn = 0;
    logic [7:0] shv = '0;
    int cs_rises = 0;
    int per_bad = 0;
    time last_rise = 0;

    function automatic logic [7:0] resp(input int n);
        return 8'((n * 37 + 11) & 255);
    endfunction

    assign spi_miso = resp(capn)[7 - bitn];

    always @(negedge spi_cs_n) begin
        capn = 0;
        bitn = 0;
    end
    always @(posedge spi_cs_n) cs_rises++;
    always @(posedge spi_sclk) begin
        if (!spi_cs_n) begin
            if (bitn != 0 && ($time - last_rise) != 16) per_bad++;
            last_rise = $time;
            shv = {shv[6:0], spi_mosi};
            if (bitn == 7) begin
                if (capn < 64) cap[capn] = shv;
                capn = capn + 1;
                bitn = 0;
            end else begin
                bitn = bitn + 1;
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 5000; i++) begin
            rd(9'h018, v);
            if (!v[0]) return;
        end
        chk(1'b0, "R2 valid never cleared", 32'h1, 32'h0);
    endtask

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 7 + 1) & 255);
    endfunction

    task automatic fill(input bit with_pat);
        for (int w = 0; w < NW; w++)
            if (with_pat)
                wr(9'(9'h100 + 4*w), {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)});
            else
                wr(9'(9'h100 + 4*w), 32'hEEEEEEEE);
    endtask

    function automatic bit k_addr(input int k);
        return k == 0 || k == 3 || k == 4 || k == 5 || k == 10 || k == 11 ||
               k == 12 || k == 13;
    endfunction
    function automatic bit k_read(input int k);
        return k == 2 || k == 10 || k == 13 || k == 14 || k == 15;
    endfunction
    function automatic bit k_nodata(input int k);
        return k == 7 || k == 8;
    endfunction

    // Run one command and check frame, data and window against the rules.
    task automatic run_check(input int k, input logic [7:0] op, input int cnt,
                             input logic [23:0] fa);
        int hdr, nd, rises0;
        logic [31:0] v;
        hdr = k_addr(k) ? 4 : 1;
        nd  = k_nodata(k) ? 0 : (cnt > PG ? PG : cnt);
        fill(!k_read(k));
        wr(9'h014, 32'(cnt));
        wr(9'h024, {8'h00, fa});
        rises0 = cs_rises;
        wr(9'h018, {18'h0, op, 1'b0, 4'(k), 1'b1});
        wait_idle();
        chk(capn == hdr + nd, $sformatf("R5/R8 frame length kind %0d cnt %0d", k, cnt),
            32'(capn), 32'(hdr + nd));
        chk(cap[0] == op, "R2 opcode byte", 32'(cap[0]), 32'(op));
        chk(cs_rises == rises0 + 1, "R10 one CS rise per frame",
            32'(cs_rises - rises0), 32'd1);
        if (hdr == 4)
            chk({cap[1], cap[2], cap[3]} == fa, "R5 address bytes",
                {8'h0, cap[1], cap[2], cap[3]}, {8'h0, fa});
        if (!k_read(k)) begin
            for (int i = 0; i < nd; i++)
                chk(cap[hdr+i] == pat(i), "R6 sent data byte", 32'(cap[hdr+i]), 32'(pat(i)));
        end else begin
            for (int w = 0; w < NW; w++) begin
                rd(9'(9'h100 + 4*w), v);
                for (int j = 0; j < 4; j++) begin
                    logic [7:0] e;
                    e = (4*w + j < nd) ? resp(hdr + 4*w + j) : 8'hEE;
                    chk(v[8*j +: 8] == e, "R7 window byte after read",
                        32'(v[8*j +: 8]), 32'(e));
                end
            end
        end
    endtask

    // ---------------- main ----------------
    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(9'h018, v); chk(v == 32'hFFFFC000, "R1 command reset", v, 32'hFFFFC000);
        rd(9'h014, v); chk(v == 0, "R1 count reset", v, 0);
        rd(9'h024, v); chk(v == 0, "R1 address reset", v, 0);
        rd(9'h004, v); chk(v == 0, "R1 mode reset", v, 0);
        rd(9'h010, v); chk(v == 0, "R1 fast reset", v, 0);
        chk(spi_cs_n == 1'b1 && spi_sclk == 1'b0, "R1 pins idle",
            {30'b0, spi_cs_n, spi_sclk}, 32'h2);

        // R11 register readback
        wr(9'h004, 32'hFFFFFFFE); rd(9'h004, v); chk(v == 2, "R11 mode", v, 2);
        wr(9'h010, 32'h00000003); rd(9'h010, v); chk(v == 3, "R11 fast", v, 3);
        wr(9'h014, 32'hABCD1234); rd(9'h014, v); chk(v == 32'h1234, "R11 count", v, 32'h1234);
        wr(9'h024, 32'hA5A55A5A); rd(9'h024, v); chk(v == 32'hA5A55A5A, "R11 addr", v, 32'hA5A55A5A);
        wr(9'h004, 0); wr(9'h010, 0);

        // R5 every kind with a short data phase
        for (int k = 0; k < 16; k++)
            run_check(k, 8'(8'h10 + 16*k + 3), 3, 24'h123456 ^ 24'(k * 24'h010101));

        // R8 count sweep for a sending and a reading kind
        for (int c = 0; c <= PG + 2; c++) begin
            run_check(0, 8'h02, c, 24'(24'h00A000 + c));
            run_check(13, 8'h03, c, 24'(24'h7F0000 + c));
        end

        // R3 / R9 disturbance during a frame
        fill(1'b0);
        wr(9'h014, 32'd4);
        wr(9'h024, 32'h00C0FFEE);
        wr(9'h018, {18'h0, 8'h03, 1'b0, 4'd13, 1'b1});
        repeat (20) @(negedge clk);
        rd(9'h018, v);
        chk(v[0] == 1'b1, "R2 valid set mid-frame", {31'b0, v[0]}, 1);
        wr(9'h018, {18'h0, 8'h77, 1'b0, 4'd2, 1'b1});
        wr(9'h014, 32'd1);
        wr(9'h024, 32'h00111111);
        wait_idle();
        chk(cap[0] == 8'h03, "R3 opcode unchanged", 32'(cap[0]), 32'h03);
        rd(9'h018, v);
        chk(v[13:1] == {8'h03, 1'b0, 4'd13}, "R3 command fields unchanged",
            {19'b0, v[13:1]}, {19'b0, 8'h03, 1'b0, 4'd13});
        chk(capn == 8, "R9 count captured", 32'(capn), 8);
        chk({cap[1], cap[2], cap[3]} == 24'hC0FFEE, "R9 address captured",
            {8'h0, cap[1], cap[2], cap[3]}, 32'h00C0FFEE);

        // R4 SCLK period and idle level
        chk(per_bad == 0, "R4 SCLK period within byte", 32'(per_bad), 0);
        chk(spi_sclk == 1'b0, "R4 SCLK idle low", {31'b0, spi_sclk}, 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 190000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule